// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Detector

This block watches eight general-purpose input lines and turns selected activity on them into a single interrupt request. Each line can be programmed independently. In level mode the line flags whenever it sits at a chosen level. In edge mode it flags on a chosen edge, or on either edge. Detected events are kept in a sticky raw status register until software acknowledges them. An enable mask decides which of those events reach the combined interrupt output.

The block samples the current pin levels and the pin direction vector every clock. It is programmed through a simple single-cycle register port: a write strobe, an address and write data, with read data returned combinationally for the presented address. Pin multiplexing and the data-port addressing belong to neighbouring logic.

Register map (byte offsets, 12-bit address). The offsets are fixed because the software driver decodes them.

| Offset | Name | Access |
|---|---|---|
| 0x404 | LEVEL_SEL | read/write |
| 0x408 | ANY_EDGE | read/write |
| 0x40C | POLARITY | read/write |
| 0x410 | ENABLE | read/write |
| 0x414 | RAW_STAT | read only |
| 0x418 | PEND_STAT | read only |
| 0x41C | ACK | write only |

In every register, bit i refers to pin i.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, LEVEL_SEL, ANY_EDGE, POLARITY, ENABLE, RAW_STAT and PEND_STAT all read 0, and `irq_out` is 0.
- R2: LEVEL_SEL (0x404), ANY_EDGE (0x408), POLARITY (0x40C) and ENABLE (0x410) store bits [7:0] of a write and read them back. Read bits [31:8] are 0.
- R3: A pin with LEVEL_SEL=0, ANY_EDGE=1 and direction 0 sets its RAW_STAT bit on any change of its level. The bit is visible at the clock edge that first samples the new level.
- R4: A pin with LEVEL_SEL=0 and ANY_EDGE=0 sets its RAW_STAT bit only when it changes to the level held in its POLARITY bit (1 means rising, 0 means falling). The opposite edge leaves the bit unchanged.
- R5: A pin with LEVEL_SEL=1 sets its RAW_STAT bit on every clock at which its level equals its POLARITY bit. Acknowledging the bit while that condition holds leaves it set. Once the condition is gone, an acknowledge clears it.
- R6: Writing ACK (0x41C) clears the RAW_STAT bits where the written value has a 1. Bits written 0 are kept.
- R7: PEND_STAT (0x418) reads RAW_STAT AND ENABLE. `irq_out` is 1 exactly when PEND_STAT is non-zero.
- R8: A pin whose direction bit is 1 (output) never produces an edge event, whatever its level does.
- R9: A set RAW_STAT bit stays set, with no time limit, until it is acknowledged, even after the pin returns to its former level.
- R10: When a detection and an acknowledge of the same bit fall on the same clock edge, the bit ends up set.
- R11: Reads of ACK or of any unmapped address return 0. Writes to RAW_STAT, PEND_STAT or unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NPINS | Current level of each pin |
| pin_dir | input | NPINS | Direction per pin, 1 = output, 0 = input |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so a register write is visible on `bus_rdata` right after its write edge. A pin change sets RAW_STAT, PEND_STAT and `irq_out` at the single clock edge that samples it. A level-mode condition is first evaluated at the edge after the configuration write takes effect. The bench drives every input at a falling edge and samples one falling edge after the rising edge that is due to update the state, so no check races its own edge. The acknowledge-versus-detect and level re-latch cases are stimulated so that both events land on one rising edge and the outcome is read at the next falling edge.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register offsets and register-select type for the
// GPIO interrupt detector. Offsets are byte addresses on a 12-bit bus.
package gpio_irq_pkg;

    localparam int unsigned OFS_LEVEL_SEL = 32'h404;
    localparam int unsigned OFS_ANY_EDGE  = 32'h408;
    localparam int unsigned OFS_POLARITY  = 32'h40C;
    localparam int unsigned OFS_ENABLE    = 32'h410;
    localparam int unsigned OFS_RAW_STAT  = 32'h414;
    localparam int unsigned OFS_PEND_STAT = 32'h418;
    localparam int unsigned OFS_ACK       = 32'h41C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_ANYEDGE,
        SEL_POLARITY,
        SEL_ENABLE,
        SEL_RAW,
        SEL_PEND,
        SEL_ACK
    } reg_sel_e;

endpackage

// File: rtl/gpio_irq_cfg.sv
// Module: gpio_irq_cfg
// Decodes the register address and holds the four configuration registers
// (level select, any-edge, polarity, enable). Produces the acknowledge
// strobe and bits for the status block.
// Assumes: one write per asserted bus_wr cycle, synchronous active-low reset.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  wr_bits,
    output reg_sel_e          sel,
    output logic [NPINS-1:0]  level_sel,
    output logic [NPINS-1:0]  any_edge,
    output logic [NPINS-1:0]  polarity,
    output logic [NPINS-1:0]  enable,
    output logic              ack_stb,
    output logic [NPINS-1:0]  ack_bits
);

    logic [NPINS-1:0] level_q, anyedge_q, polarity_q, enable_q;

    // Map the presented address to one register select code.
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_LEVEL_SEL)) sel = SEL_LEVEL;
        else if (bus_addr == ADDR_W'(OFS_ANY_EDGE))  sel = SEL_ANYEDGE;
        else if (bus_addr == ADDR_W'(OFS_POLARITY))  sel = SEL_POLARITY;
        else if (bus_addr == ADDR_W'(OFS_ENABLE))    sel = SEL_ENABLE;
        else if (bus_addr == ADDR_W'(OFS_RAW_STAT))  sel = SEL_RAW;
        else if (bus_addr == ADDR_W'(OFS_PEND_STAT)) sel = SEL_PEND;
        else if (bus_addr == ADDR_W'(OFS_ACK))       sel = SEL_ACK;
        else                                         sel = SEL_NONE;
    end

    // Update the configuration registers on writes to their offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q    <= '0;
            anyedge_q  <= '0;
            polarity_q <= '0;
            enable_q   <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_LEVEL:    level_q    <= wr_bits;
                SEL_ANYEDGE:  anyedge_q  <= wr_bits;
                SEL_POLARITY: polarity_q <= wr_bits;
                SEL_ENABLE:   enable_q   <= wr_bits;
                default: ;
            endcase
        end
    end

    // Acknowledge is a pulse that lives only in the write cycle.
    always_comb begin
        ack_stb  = bus_wr && (sel == SEL_ACK);
        ack_bits = ack_stb ? wr_bits : '0;
    end

    assign level_sel = level_q;
    assign any_edge  = anyedge_q;
    assign polarity  = polarity_q;
    assign enable    = enable_q;

endmodule

// File: rtl/gpio_irq_pin.sv
// Module: gpio_irq_pin
// Detection cell for one pin. Remembers the level sampled at the last edge
// and reports a hit when the programmed level or edge condition is met.
// Assumes: pin is already synchronous to clk; direction 1 marks an output,
// which is excluded from edge detection only.
module gpio_irq_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic dir_out,
    input  logic level_mode,
    input  logic any_edge,
    input  logic polarity,
    output logic hit
);

    logic prev_q;
    logic changed, at_level, edge_hit, level_hit;

    // Track the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin;
    end

    // Evaluate edge and level conditions for this pin.
    always_comb begin
        changed   = pin ^ prev_q;
        at_level  = ~(pin ^ polarity);
        edge_hit  = ~level_mode & ~dir_out & changed & (any_edge | at_level);
        level_hit = level_mode & at_level;
        hit       = edge_hit | level_hit;
    end

endmodule

// File: rtl/gpio_irq_status.sv
// Module: gpio_irq_status
// Sticky raw status register with write-one-to-clear acknowledge, the
// enable-masked view and the combined interrupt line.
// Assumes: a detection in the same cycle as an acknowledge wins.
module gpio_irq_status #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hits,
    input  logic [NPINS-1:0] ack_bits,
    input  logic [NPINS-1:0] enable,
    output logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] pend,
    output logic             irq
);

    logic [NPINS-1:0] raw_q, raw_d;

    // Next raw status: keep unacknowledged bits, then add new hits.
    always_comb begin
        raw_d = (raw_q & ~ack_bits) | hits;
    end

    // Hold the raw status.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    // Masked view and combined request.
    always_comb begin
        pend = raw_q & enable;
        irq  = |pend;
    end

    assign raw = raw_q;

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect (top)
// Per-pin GPIO interrupt detector: configuration registers, one detection
// cell per pin, sticky status and a combinational read port.
// Assumes: pin_in and pin_dir are synchronous to clk; NPINS <= DATA_W.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  pin_dir,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    localparam int PAD_W = DATA_W - NPINS;

    reg_sel_e         sel;
    logic [NPINS-1:0] cfg_level, cfg_anyedge, cfg_polarity, cfg_enable;
    logic             ack_stb;
    logic [NPINS-1:0] ack_bits;
    logic [NPINS-1:0] pin_hits;
    logic [NPINS-1:0] raw_status, pend_status;
    logic [NPINS-1:0] wr_bits;
    logic             unused_wdata_hi;

    assign wr_bits         = bus_wdata[NPINS-1:0];
    assign unused_wdata_hi = ^{bus_wdata[DATA_W-1:NPINS], ack_stb};

    gpio_irq_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_bits   (wr_bits),
        .sel       (sel),
        .level_sel (cfg_level),
        .any_edge  (cfg_anyedge),
        .polarity  (cfg_polarity),
        .enable    (cfg_enable),
        .ack_stb   (ack_stb),
        .ack_bits  (ack_bits)
    );

    // One detection cell per pin.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (pin_in[i]),
            .dir_out    (pin_dir[i]),
            .level_mode (cfg_level[i]),
            .any_edge   (cfg_anyedge[i]),
            .polarity   (cfg_polarity[i]),
            .hit        (pin_hits[i])
        );
    end

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits     (pin_hits),
        .ack_bits (ack_bits),
        .enable   (cfg_enable),
        .raw      (raw_status),
        .pend     (pend_status),
        .irq      (irq_out)
    );

    // Return the selected register, zero-extended; write-only and unmapped read 0.
    always_comb begin
        case (sel)
            SEL_LEVEL:    bus_rdata = {{PAD_W{1'b0}}, cfg_level};
            SEL_ANYEDGE:  bus_rdata = {{PAD_W{1'b0}}, cfg_anyedge};
            SEL_POLARITY: bus_rdata = {{PAD_W{1'b0}}, cfg_polarity};
            SEL_ENABLE:   bus_rdata = {{PAD_W{1'b0}}, cfg_enable};
            SEL_RAW:      bus_rdata = {{PAD_W{1'b0}}, raw_status};
            SEL_PEND:     bus_rdata = {{PAD_W{1'b0}}, pend_status};
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
// Module: gpio_irq_detect_chk
// Property checker bound to gpio_irq_detect. Observes ports and the
// configuration and status vectors driven by separate submodules.
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_dir,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  wr_bits,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out,
    input logic [NPINS-1:0]  level_sel,
    input logic [NPINS-1:0]  polarity,
    input logic [NPINS-1:0]  raw
);

    logic [NPINS-1:0] ack_seen;

    // Bits acknowledged by the bus in this cycle, seen from the ports.
    always_comb begin
        ack_seen = (bus_wr && bus_addr == ADDR_W'(OFS_ACK)) ? wr_bits : '0;
    end

    // R9: a raw bit only drops when it was acknowledged on the previous edge.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(raw) & ~$past(ack_seen) & ~raw) == '0));

    // R5: a level-mode pin at its polarity is set on the following edge.
    p_level_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (($past(level_sel) & ~($past(pin_in) ^ $past(polarity)) & ~raw) == '0));

    // R8: output pins in edge mode never gain a raw bit.
    p_output_no_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((~$past(raw) & raw & $past(pin_dir) & ~$past(level_sel)) == '0));

    // R7: the interrupt line agrees with a PEND_STAT read.
    p_irq_matches_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_PEND_STAT)) |-> (irq_out == (bus_rdata != '0)));

    // R11: the ACK offset always reads 0.
    p_ack_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_ACK)) |-> (bus_rdata == '0));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .pin_dir   (pin_dir),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wr_bits   (bus_wdata[NPINS-1:0]),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .level_sel (cfg_level),
    .polarity  (cfg_polarity),
    .raw       (raw_status)
);

// File: tb/sim_gpio_irq_detect.sv
// Directed bench for gpio_irq_detect: one task per scenario.
module sim_gpio_irq_detect;

    localparam logic [11:0] A_LEVEL = 12'h404;
    localparam logic [11:0] A_ANY   = 12'h408;
    localparam logic [11:0] A_POL   = 12'h40C;
    localparam logic [11:0] A_EN    = 12'h410;
    localparam logic [11:0] A_RAW   = 12'h414;
    localparam logic [11:0] A_PEND  = 12'h418;
    localparam logic [11:0] A_ACK   = 12'h41C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_dir = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_irq_detect u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restore();
        wr(A_LEVEL, 0); wr(A_ANY, 0); wr(A_POL, 0); wr(A_EN, 0);
        pin_dir = '0;
        pins(8'h00);
        idle(1);
        wr(A_ACK, 32'hFF);
    endtask

    task automatic t_reset();
        rd("R1 level_sel", A_LEVEL, 0);
        rd("R1 any_edge",  A_ANY,   0);
        rd("R1 polarity",  A_POL,   0);
        rd("R1 enable",    A_EN,    0);
        rd("R1 raw",       A_RAW,   0);
        rd("R1 pend",      A_PEND,  0);
        check("R1 irq", {31'd0, irq_out}, 0);
    endtask

    task automatic t_regs();
        wr(A_LEVEL, 32'hA5); rd("R2 level_sel", A_LEVEL, 32'hA5);
        wr(A_ANY,   32'h3C); rd("R2 any_edge",  A_ANY,   32'h3C);
        wr(A_POL,   32'h0F); rd("R2 polarity",  A_POL,   32'h0F);
        wr(A_EN, 32'hFFFFFF5A); rd("R2 enable upper zero", A_EN, 32'h5A);
        restore();
    endtask

    task automatic t_any_edge();
        wr(A_ANY, 32'h01);
        pins(8'h01); rd("R3 rising sets", A_RAW, 32'h01);
        wr(A_ACK, 32'h01); rd("R3 ack", A_RAW, 32'h00);
        pins(8'h00); rd("R3 falling sets", A_RAW, 32'h01);
        restore();
    endtask

    task automatic t_one_edge();
        wr(A_POL, 32'h04);
        pins(8'h04); rd("R4 rising with polarity 1", A_RAW, 32'h04);
        wr(A_ACK, 32'h04);
        pins(8'h00); rd("R4 falling ignored with polarity 1", A_RAW, 32'h00);
        pins(8'h08); rd("R4 rising ignored with polarity 0", A_RAW, 32'h00);
        pins(8'h00); rd("R4 falling with polarity 0", A_RAW, 32'h08);
        restore();
    endtask

    task automatic t_level();
        wr(A_POL, 32'h10); wr(A_LEVEL, 32'h10);
        idle(1); rd("R5 not at level", A_RAW, 32'h00);
        pins(8'h10); rd("R5 at level sets", A_RAW, 32'h10);
        wr(A_ACK, 32'h10); rd("R5 ack does not stick", A_RAW, 32'h10);
        pins(8'h00); rd("R5 held after level gone", A_RAW, 32'h10);
        wr(A_ACK, 32'h10); idle(2); rd("R5 ack after level gone", A_RAW, 32'h00);
        restore();
    endtask

    task automatic t_ack_mask();
        wr(A_ANY, 32'h06);
        pins(8'h06); rd("R6 setup raw", A_RAW, 32'h06);
        wr(A_EN, 32'h04);
        rd("R7 pend is raw and enable", A_PEND, 32'h04);
        check("R7 irq high", {31'd0, irq_out}, 1);
        wr(A_EN, 32'h01);
        rd("R7 pend masked off", A_PEND, 32'h00);
        check("R7 irq low", {31'd0, irq_out}, 0);
        wr(A_ACK, 32'h02); rd("R6 ack clears only ones", A_RAW, 32'h04);
        restore();
    endtask

    task automatic t_dir();
        pin_dir = 8'h20;
        wr(A_ANY, 32'h20);
        pins(8'h20); rd("R8 output rise ignored", A_RAW, 32'h00);
        pins(8'h00); rd("R8 output fall ignored", A_RAW, 32'h00);
        pin_dir = 8'h00;
        pins(8'h20); rd("R8 input edge sets", A_RAW, 32'h20);
        restore();
    endtask

    task automatic t_sticky();
        wr(A_POL, 32'h02);
        pins(8'h02); rd("R9 set", A_RAW, 32'h02);
        pins(8'h00); idle(10);
        rd("R9 still set", A_RAW, 32'h02);
        restore();
    endtask

    task automatic t_priority();
        wr(A_ANY, 32'h01);
        pins(8'h01); wr(A_ACK, 32'h01);
        rd("R10 setup clear", A_RAW, 32'h00);
        @(negedge clk);
        pin_in = 8'h00;
        bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h01;
        @(negedge clk);
        bus_wr = 1'b0;
        rd("R10 detect wins over ack", A_RAW, 32'h01);
        restore();
    endtask

    task automatic t_unmapped();
        wr(A_ANY, 32'h80);
        pins(8'h80); rd("R11 setup raw", A_RAW, 32'h80);
        rd("R11 ack reads zero", A_ACK, 0);
        rd("R11 unmapped reads zero", 12'h420, 0);
        rd("R11 low address reads zero", 12'h000, 0);
        wr(A_RAW, 32'h00);  rd("R11 raw write ignored", A_RAW, 32'h80);
        wr(A_PEND, 32'h00); rd("R11 pend write ignored", A_RAW, 32'h80);
        wr(12'h500, 32'hFF); rd("R11 unmapped write keeps enable", A_EN, 32'h00);
        restore();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_any_edge();
        t_one_edge();
        t_level();
        t_ack_mask();
        t_dir();
        t_sticky();
        t_priority();
        t_unmapped();
        finish_run();
    end

endmodule